// File: doc/BRIEF.md
# Serial DAC Write Controller

This block is the host-side master for a 16-bit serial-input DAC. A client hands it one code at a time over a valid/ready handshake, together with the number of significant bits in that code and a choice of update mode. The controller then drives the slave's four control wires: an active-low chip select, a serial clock, a serial data line and an active-low load strobe. It keeps every minimum interval the slave needs, and each interval is counted in system clock cycles.

Each interval is given in nanoseconds as a parameter. It is converted to cycles of the system clock by rounding up from the clock period parameter. After reset, the controller holds off for the power-up interval before it sends the first frame. Codes shorter than the full word are placed at the top of the word, and zeros fill the bits below. In immediate mode the load strobe stays low, so the slave's output follows each frame as soon as chip select rises. In deferred mode the strobe stays high during the frame and is then pulsed low once, after a set delay.

Top module: `dac_serial_writer`

## Requirements
- R1: While `rst_n` is low, `dac_cs_n` is 1, `dac_sclk` is 0, `dac_ld_n` is 1 and `req_ready` is 0.
- R2: After `rst_n` is released, `req_ready` stays 0 and `dac_cs_n` stays 1 for at least ceil(PWRUP_NS·1000/CLK_PS) cycles.
- R3: Each frame has exactly 16 rising edges of `dac_sclk` while `dac_cs_n` is low, and sends the most significant bit first. `dac_sdi` changes only when `dac_sclk` falls and is stable at each rising edge.
- R4: When `req_len` is between 1 and 15, the bits `req_data[len-1:0]` are sent as the top bits of the word and zeros fill the bits below; bits of `req_data` at or above `len` are ignored. When `req_len` is 0 or 16 or more, all 16 bits of `req_data` are sent.
- R5: The high phase and the low phase of `dac_sclk` each last at least ceil(SCK_HALF_NS·1000/CLK_PS) cycles. `dac_sclk` is 0 whenever `dac_cs_n` is 1.
- R6: The first rise of `dac_sclk` comes at least ceil(CS_LEAD_NS·1000/CLK_PS) cycles after `dac_cs_n` falls. `dac_cs_n` rises at least ceil(CS_LAG_NS·1000/CLK_PS) cycles after the last fall of `dac_sclk`.
- R7: `dac_cs_n` stays high for at least ceil(CS_GAP_NS·1000/CLK_PS) cycles between two frames.
- R8: Immediate mode (`req_defer`=0): `dac_ld_n` is 0 from the cycle the word is accepted, through the frame, and afterwards until a deferred word is accepted.
- R9: Deferred mode (`req_defer`=1): `dac_ld_n` is 1 while `dac_cs_n` is low. After `dac_cs_n` rises, `dac_ld_n` gives exactly one low pulse. The pulse starts at least ceil(LD_DLY_NS·1000/CLK_PS) cycles after the rise and lasts at least ceil(LD_WID_NS·1000/CLK_PS) cycles.
- R10: `req_ready` drops in the cycle after a word is accepted. It stays 0 until both the inter-frame gap and any deferred load pulse are complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client offers a word |
| req_ready | output | 1 | Controller can accept a word |
| req_data | input | WORD_W | Code, right-aligned |
| req_len | input | LEN_W | Number of significant bits (0 = full word) |
| req_defer | input | 1 | 1 = deferred load pulse, 0 = immediate load |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdi | output | 1 | Serial data, changes on falling clock |
| dac_ld_n | output | 1 | Load strobe, active low |

## Verification
All four slave-side outputs come straight from flops. Each one moves in the cycle after the posedge where the controller's state counter reaches zero, and `req_ready` falls one cycle after the accepting edge. The bench samples 1 ns after each rising edge. It measures every interval as the number of samples a level held before it changed, so lead, lag, phase, gap, load delay and load width are compared directly against the rounded-up cycle minimums. The power-up interval is counted from the first sample after reset release up to the first falling edge of chip select. The received word and the load-pulse count are checked once `req_ready` returns, which is the point where the frame and any deferred pulse are complete.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;

    typedef enum logic [2:0] {
        S_PWRUP,
        S_IDLE,
        S_LEAD,
        S_SCKH,
        S_SCKL,
        S_LAG,
        S_POST,
        S_PULSE
    } wr_state_e;

    // Interval in ns converted to whole clock cycles, rounded up, never zero
    function automatic int ns_to_cyc(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_wr_pad.sv
module dac_wr_pad #(
    parameter int WORD_W = 16,
    parameter int LEN_W  = 5
) (
    input  logic [WORD_W-1:0] raw,
    input  logic [LEN_W-1:0]  len,
    output logic [WORD_W-1:0] word
);
    localparam logic [LEN_W-1:0] FULL = LEN_W'(WORD_W);

    logic [WORD_W-1:0] keep;
    logic [LEN_W-1:0]  sh;

    always_comb begin
        keep = raw & ~({WORD_W{1'b1}} << len);
        sh   = FULL - len;
        if (len == '0 || len >= FULL) begin
            word = raw;
        end else begin
            word = keep << sh;
        end
    end
endmodule

// File: rtl/dac_wr_shreg.sv
module dac_wr_shreg #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] din,
    output logic              msb
);
    logic [WORD_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (load) begin
            data_d = din;
        end else if (shift) begin
            data_d = {data_q[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign msb = data_q[WORD_W-1];
endmodule

// File: rtl/dac_serial_writer.sv
module dac_serial_writer
    import dac_wr_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int CLK_PS      = 4000,
    parameter int SCK_HALF_NS = 10,
    parameter int CS_LEAD_NS  = 10,
    parameter int CS_LAG_NS   = 10,
    parameter int CS_GAP_NS   = 30,
    parameter int LD_DLY_NS   = 30,
    parameter int LD_WID_NS   = 30,
    parameter int PWRUP_NS    = 10000,
    localparam int LEN_W      = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WORD_W-1:0] req_data,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_defer,
    output logic              dac_cs_n,
    output logic              dac_sclk,
    output logic              dac_sdi,
    output logic              dac_ld_n
);
    localparam int HALF_C  = ns_to_cyc(SCK_HALF_NS, CLK_PS);
    localparam int LEAD_C  = ns_to_cyc(CS_LEAD_NS, CLK_PS);
    localparam int LAG_C   = ns_to_cyc(CS_LAG_NS, CLK_PS);
    localparam int GAP_C   = ns_to_cyc(CS_GAP_NS, CLK_PS);
    localparam int LDDLY_C = ns_to_cyc(LD_DLY_NS, CLK_PS);
    localparam int LDW_C   = ns_to_cyc(LD_WID_NS, CLK_PS);
    localparam int PWR_C   = ns_to_cyc(PWRUP_NS, CLK_PS);
    localparam int POSTD_C = imax(GAP_C, LDDLY_C);
    localparam int CNT_MAX = imax(PWR_C, imax(imax(HALF_C, LDW_C),
                                  imax(imax(LEAD_C, LAG_C), POSTD_C)));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int BIT_W   = $clog2(WORD_W);

    typedef struct packed {
        wr_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic [BIT_W-1:0] bits;
        logic             cs_n;
        logic             sclk;
        logic             ld_n;
        logic             defer;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic              load_word;
    logic              shift_bit;
    logic              cnt_done;
    logic [WORD_W-1:0] padded;

    dac_wr_pad #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_pad (
        .raw  (req_data),
        .len  (req_len),
        .word (padded)
    );

    dac_wr_shreg #(.WORD_W(WORD_W)) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_word),
        .shift (shift_bit),
        .din   (padded),
        .msb   (dac_sdi)
    );

    always_comb begin
        ctl_d     = ctl_q;
        load_word = 1'b0;
        shift_bit = 1'b0;
        cnt_done  = (ctl_q.cnt == '0);
        if (!cnt_done) begin
            ctl_d.cnt = ctl_q.cnt - 1'b1;
        end
        case (ctl_q.state)
            S_PWRUP: begin
                if (cnt_done) begin
                    ctl_d.state = S_IDLE;
                end
            end
            S_IDLE: begin
                if (req_valid) begin
                    load_word   = 1'b1;
                    ctl_d.defer = req_defer;
                    ctl_d.cs_n  = 1'b0;
                    ctl_d.ld_n  = req_defer;
                    ctl_d.bits  = BIT_W'(WORD_W - 1);
                    ctl_d.cnt   = CNT_W'(LEAD_C - 1);
                    ctl_d.state = S_LEAD;
                end
            end
            S_LEAD: begin
                if (cnt_done) begin
                    ctl_d.sclk  = 1'b1;
                    ctl_d.cnt   = CNT_W'(HALF_C - 1);
                    ctl_d.state = S_SCKH;
                end
            end
            S_SCKH: begin
                if (cnt_done) begin
                    ctl_d.sclk = 1'b0;
                    if (ctl_q.bits == '0) begin
                        ctl_d.cnt   = CNT_W'(LAG_C - 1);
                        ctl_d.state = S_LAG;
                    end else begin
                        shift_bit   = 1'b1;
                        ctl_d.bits  = ctl_q.bits - 1'b1;
                        ctl_d.cnt   = CNT_W'(HALF_C - 1);
                        ctl_d.state = S_SCKL;
                    end
                end
            end
            S_SCKL: begin
                if (cnt_done) begin
                    ctl_d.sclk  = 1'b1;
                    ctl_d.cnt   = CNT_W'(HALF_C - 1);
                    ctl_d.state = S_SCKH;
                end
            end
            S_LAG: begin
                if (cnt_done) begin
                    ctl_d.cs_n  = 1'b1;
                    ctl_d.cnt   = ctl_q.defer ? CNT_W'(POSTD_C - 1) : CNT_W'(GAP_C - 1);
                    ctl_d.state = S_POST;
                end
            end
            S_POST: begin
                if (cnt_done) begin
                    if (ctl_q.defer) begin
                        ctl_d.ld_n  = 1'b0;
                        ctl_d.cnt   = CNT_W'(LDW_C - 1);
                        ctl_d.state = S_PULSE;
                    end else begin
                        ctl_d.state = S_IDLE;
                    end
                end
            end
            S_PULSE: begin
                if (cnt_done) begin
                    ctl_d.ld_n  = 1'b1;
                    ctl_d.state = S_IDLE;
                end
            end
            default: ctl_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state <= S_PWRUP;
            ctl_q.cnt   <= CNT_W'(PWR_C - 1);
            ctl_q.bits  <= '0;
            ctl_q.cs_n  <= 1'b1;
            ctl_q.sclk  <= 1'b0;
            ctl_q.ld_n  <= 1'b1;
            ctl_q.defer <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.state == S_IDLE);
    assign dac_cs_n  = ctl_q.cs_n;
    assign dac_sclk  = ctl_q.sclk;
    assign dac_ld_n  = ctl_q.ld_n;

    // R5
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_cs_n |-> !dac_sclk);

    // R3
    sdi_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sclk) |-> $stable(dac_sdi));

    // R9
    ld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && ctl_q.defer) |-> dac_ld_n);

    // R8
    ld_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && !ctl_q.defer) |-> !dac_ld_n);

    // R10
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dac_cs_n && dac_ld_n == ctl_q.defer));
endmodule

// File: tb/tb_dac_serial_writer.sv
`timescale 1ns/1ps
module tb_dac_serial_writer;
    localparam int CLK_PS = 4000;
    function automatic int cyc(input int ns);
        int c;
        c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int HALF_C  = cyc(10);
    localparam int LEAD_C  = cyc(10);
    localparam int LAG_C   = cyc(10);
    localparam int GAP_C   = cyc(30);
    localparam int LDDLY_C = cyc(30);
    localparam int LDW_C   = cyc(30);
    localparam int PWR_C   = cyc(10000);

    // {data, len, defer, expected word}
    localparam logic [37:0] VEC [8] = '{
        {16'hA5C3, 5'd16, 1'b0, 16'hA5C3},
        {16'h0001, 5'd16, 1'b1, 16'h0001},
        {16'h0ABC, 5'd12, 1'b0, 16'hABC0},
        {16'h005A, 5'd8,  1'b1, 16'h5A00},
        {16'h0001, 5'd1,  1'b0, 16'h8000},
        {16'hFFFF, 5'd0,  1'b1, 16'hFFFF},
        {16'h1234, 5'd20, 1'b0, 16'h1234},
        {16'hFFF9, 5'd4,  1'b1, 16'h9000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [15:0] req_data = '0;
    logic [4:0] req_len = '0;
    logic req_defer = 1'b0;
    logic dac_cs_n, dac_sclk, dac_sdi, dac_ld_n;

    always #2 clk = ~clk;

    dac_serial_writer dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_data(req_data), .req_len(req_len), .req_defer(req_defer),
        .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdi(dac_sdi), .dac_ld_n(dac_ld_n)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor state
    logic prev_cs, prev_sclk, prev_ld, prev_sdi, prev_ready;
    int cs_run, sclk_run, ld_run, nrise, pulses, last_nrise;
    bit first_frame, have_mode, mode_defer, pend_defer;
    logic [15:0] shift_word, last_word;

    always begin
        @(posedge clk);
        #1;
        if (!rst_n) begin
            prev_cs = 1; prev_sclk = 0; prev_ld = 1; prev_sdi = 0; prev_ready = 0;
            cs_run = 0; sclk_run = 0; ld_run = 0; nrise = 0; pulses = 0;
            first_frame = 1; have_mode = 0; shift_word = '0;
        end else begin
            if (dac_cs_n != prev_cs) begin
                if (!dac_cs_n) begin
                    if (first_frame) chk(cs_run >= PWR_C, "R2", "power-up wait", cs_run, PWR_C);
                    else chk(cs_run >= GAP_C, "R7", "cs high gap", cs_run, GAP_C);
                    first_frame = 0; nrise = 0; pulses = 0;
                    mode_defer = pend_defer; have_mode = 1;
                end else begin
                    chk(!dac_sclk && sclk_run >= LAG_C, "R6", "cs lag", sclk_run, LAG_C);
                    last_word = shift_word; last_nrise = nrise;
                end
            end
            if (dac_sclk != prev_sclk) begin
                if (dac_sclk) begin
                    chk(!dac_cs_n, "R5", "cs low at sclk rise", int'(dac_cs_n), 0);
                    if (nrise == 0) chk(cs_run >= LEAD_C, "R6", "cs lead", cs_run, LEAD_C);
                    else chk(sclk_run >= HALF_C, "R5", "sclk low phase", sclk_run, HALF_C);
                    chk(dac_sdi == prev_sdi, "R3", "sdi stable at rise", int'(dac_sdi), int'(prev_sdi));
                    shift_word = {shift_word[14:0], dac_sdi};
                    nrise++;
                end else begin
                    chk(sclk_run >= HALF_C, "R5", "sclk high phase", sclk_run, HALF_C);
                end
            end
            if (dac_cs_n && dac_sclk) chk(0, "R5", "sclk high while cs high", 1, 0);
            if (have_mode && !dac_cs_n)
                chk(dac_ld_n == mode_defer, mode_defer ? "R9" : "R8", "ld level in frame",
                    int'(dac_ld_n), int'(mode_defer));
            if (have_mode && !mode_defer && dac_cs_n)
                chk(!dac_ld_n, "R8", "ld low after immediate frame", int'(dac_ld_n), 0);
            if (dac_ld_n != prev_ld && dac_cs_n && prev_cs) begin
                chk(mode_defer, "R8", "ld toggled in immediate mode", 0, 1);
                if (!dac_ld_n) chk(cs_run >= LDDLY_C, "R9", "ld delay", cs_run, LDDLY_C);
                else begin
                    chk(ld_run >= LDW_C, "R9", "ld width", ld_run, LDW_C);
                    pulses++;
                end
            end
            if (req_ready && !dac_cs_n) chk(0, "R10", "ready during frame", 1, 0);
            if (req_ready && !prev_ready && have_mode) begin
                chk(dac_cs_n && cs_run >= GAP_C, "R10", "ready before gap", cs_run, GAP_C);
                if (mode_defer) chk(dac_ld_n && pulses == 1, "R10", "ready before pulse", pulses, 1);
            end
            cs_run   = (dac_cs_n != prev_cs) ? 1 : cs_run + 1;
            sclk_run = (dac_sclk != prev_sclk) ? 1 : sclk_run + 1;
            ld_run   = (dac_ld_n != prev_ld) ? 1 : ld_run + 1;
            prev_cs = dac_cs_n; prev_sclk = dac_sclk; prev_ld = dac_ld_n;
            prev_sdi = dac_sdi; prev_ready = req_ready;
        end
    end

    task automatic wait_ready(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!req_ready);
    endtask

    task automatic check_reset_outputs();
        chk(dac_cs_n == 1, "R1", "cs_n in reset", int'(dac_cs_n), 1);
        chk(dac_sclk == 0, "R1", "sclk in reset", int'(dac_sclk), 0);
        chk(dac_ld_n == 1, "R1", "ld_n in reset", int'(dac_ld_n), 1);
        chk(req_ready == 0, "R1", "ready in reset", int'(req_ready), 0);
    endtask

    task automatic send(input logic [37:0] v);
        int n;
        wait_ready(n);
        pend_defer = v[16];
        req_data   = v[37:22];
        req_len    = v[21:17];
        req_defer  = v[16];
        req_valid  = 1;
        @(negedge clk);
        chk(!req_ready, "R10", "ready after accept", int'(req_ready), 0);
        req_valid = 0;
        wait_ready(n);
        chk(last_nrise == 16, "R3", "sclk rises per frame", last_nrise, 16);
        chk(last_word == v[15:0], "R4", "received word", int'(last_word), int'(v[15:0]));
        chk(pulses == int'(v[16]), "R9", "load pulses", pulses, int'(v[16]));
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check_reset_outputs();
        rst_n = 1;
        wait_ready(n);
        chk(n >= PWR_C, "R2", "cycles to ready", n, PWR_C);

        for (int i = 0; i < 8; i++) send(VEC[i]);

        // Back-to-back words with valid held high
        pend_defer = 0; req_data = 16'h00C3; req_len = 5'd8; req_defer = 0; req_valid = 1;
        @(negedge clk);
        req_data = 16'h0F0F; req_len = 5'd16; req_defer = 1;
        wait_ready(n);
        chk(last_word == 16'hC300, "R4", "first back-to-back word", int'(last_word), 16'hC300);
        pend_defer = 1;
        @(negedge clk);
        req_valid = 0;
        wait_ready(n);
        chk(last_word == 16'h0F0F, "R4", "second back-to-back word", int'(last_word), 16'h0F0F);
        chk(pulses == 1, "R9", "pulse after deferred word", pulses, 1);

        // Reset in the middle of a frame
        pend_defer = 1; req_data = 16'hBEEF; req_len = 5'd16; req_defer = 1; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        repeat (20) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        check_reset_outputs();
        rst_n = 1;
        wait_ready(n);
        chk(n >= PWR_C, "R2", "cycles to ready after reset", n, PWR_C);
        send({16'h0003, 5'd2, 1'b0, 16'hC000});

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule